// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer ratio. It does not use one wide counter. A small prescaler counts either P+1 or P input cycles. Two down-counters steer it: a swallow count and a main count. The swallow count keeps the prescaler at P+1 for its first prescaler cycles. After that the prescaler counts P until the main count runs out. One output period therefore spans P·B + A input cycles. P is a power of two, set as 2 to the power of a parameter.

The ratio can be programmed in two ways. In split mode the two counts are given directly. In ratio mode a requested N is split inside the block into B = N div P and A = N mod P. The counters take new values only at the reload point, which is the last input cycle of an output period. At that point the block emits a single-cycle output pulse and starts the next period with no lost cycle. A flag reports when the configuration that is running cannot produce the intended ratio.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst` is high, `div_pulse` is low. The counters and `cfg_invalid` load from the configuration present at the reset edge.
- R2: In split mode (`cfg_by_ratio`=0) with `cfg_main` ≥ 1 and `cfg_main` ≥ `cfg_swallow`, consecutive `div_pulse` rising edges are exactly P·`cfg_main` + `cfg_swallow` input cycles apart.
- R3: Each prescaler cycle lasts P+1 input cycles while the swallow count is nonzero, and P input cycles once it is zero. Both counts change only at the end of a prescaler cycle, and the main count drops by one there.
- R4: `div_pulse` is high for exactly one input cycle per output period. The next period starts in the following cycle, with no idle cycle in between.
- R5: In ratio mode (`cfg_by_ratio`=1), the main count is `cfg_ratio` shifted right by log2(P) and the swallow count is the low log2(P) bits of `cfg_ratio`. For `cfg_ratio` ≥ P·(P−1), the period is exactly `cfg_ratio` cycles and `cfg_invalid` is 0.
- R6: In split mode, `cfg_invalid` is 1 when `cfg_main` < `cfg_swallow` or `cfg_main` = 0. In that case the period ends when the main count expires, so it is `cfg_main`·(P+1) cycles when 1 ≤ `cfg_main` < `cfg_swallow`. A main count of 0 behaves like a main count of 1.
- R7: In ratio mode, `cfg_invalid` is 1 when `cfg_ratio` < P·(P−1). The period then follows the split values under the rules of R2 and R6.
- R8: Configuration inputs are sampled only at the reload point. A change made during a period, including a short-lived intermediate value, does not alter that period's length or its `cfg_invalid` value. It takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_by_ratio | input | 1 | 1: derive counts from `cfg_ratio`; 0: use `cfg_swallow` and `cfg_main` |
| cfg_swallow | input | CNT_W | Swallow count A in split mode |
| cfg_main | input | CNT_W | Main count B in split mode |
| cfg_ratio | input | CNT_W+PRE_LOG2 | Requested ratio N in ratio mode |
| div_pulse | output | 1 | One-cycle pulse at the start of every output period |
| cfg_invalid | output | 1 | The configuration of the running period is invalid |

## Verification
The assertions assume that `rst` is asserted from time zero, so the counters hold defined values before any property is evaluated. They also assume that every period lasts at least two input cycles. P ≥ 2 guarantees this for any configuration. The stimulus changes configuration only on falling clock edges. It mixes in-period changes and short-lived intermediate values, including invalid ones, so the sampling rule at reload is exercised. The scoreboard predicts each period's length and flag from the last value present before the reload.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Lowest N that every value at or above it can reach with B >= A.
  function automatic int unsigned min_cont_ratio(input int unsigned p);
    return p * (p - 1);
  endfunction

  // Prescaler start value: it counts from this value down to zero.
  function automatic int unsigned pre_start(input logic swallow, input int unsigned p);
    return swallow ? p : p - 1;
  endfunction

endpackage

// File: rtl/psd_cfg_front.sv
module psd_cfg_front
  import psd_pkg::*;
#(
  parameter int PL = 2,
  parameter int BW = 6,
  localparam int NW = BW + PL,
  localparam int P  = 1 << PL
) (
  input  logic          by_ratio,
  input  logic [BW-1:0] dir_a,
  input  logic [BW-1:0] dir_b,
  input  logic [NW-1:0] ratio_n,
  output logic [BW-1:0] sel_a,
  output logic [BW-1:0] sel_b,
  output logic          sel_bad
);
  localparam logic [NW-1:0] NMIN = NW'(min_cont_ratio(P));

  logic [BW-1:0] split_a;
  logic [BW-1:0] split_b;

  if (BW > PL) begin : g_pad
    assign split_a = {{(BW-PL){1'b0}}, ratio_n[PL-1:0]};
  end else begin : g_nopad
    assign split_a = ratio_n[BW-1:0] & BW'(P - 1);
  end

  assign split_b = ratio_n[NW-1:PL];

  always_comb begin
    if (by_ratio) begin
      sel_a   = split_a;
      sel_b   = split_b;
      sel_bad = (ratio_n < NMIN);
    end else begin
      sel_a   = dir_a;
      sel_b   = dir_b;
      sel_bad = (dir_b < dir_a) || (dir_b == '0);
    end
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int PL = 2,
  localparam int P   = 1 << PL,
  localparam int PCW = PL + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           swallow_nxt,
  output logic [PCW-1:0] pre_cnt,
  output logic           pre_tc
);
  assign pre_tc = (pre_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || pre_tc) pre_cnt <= PCW'(pre_start(swallow_nxt, P));
    else               pre_cnt <= pre_cnt - PCW'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PCW'(P)); // R3
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_tc,
  input  logic [BW-1:0] ld_a,
  input  logic [BW-1:0] ld_b,
  input  logic          ld_bad,
  output logic [BW-1:0] a_cnt,
  output logic [BW-1:0] b_cnt,
  output logic          swallow_nxt,
  output logic          end_evt,
  output logic          bad_q
);
  logic [BW-1:0] a_nxt;
  logic [BW-1:0] b_nxt;

  assign end_evt = pre_tc && (b_cnt <= BW'(1));

  always_comb begin
    if (rst || end_evt) begin
      a_nxt = ld_a;
      b_nxt = ld_b;
    end else if (pre_tc) begin
      a_nxt = (a_cnt != '0) ? a_cnt - BW'(1) : a_cnt;
      b_nxt = b_cnt - BW'(1);
    end else begin
      a_nxt = a_cnt;
      b_nxt = b_cnt;
    end
  end

  assign swallow_nxt = (a_nxt != '0);

  always_ff @(posedge clk) begin
    a_cnt <= a_nxt;
    b_cnt <= b_nxt;
    if (rst || end_evt) bad_q <= ld_bad;
  end

  AST_COUNTS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pre_tc |=> $stable(a_cnt) && $stable(b_cnt)); // R3
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    !end_evt |=> $stable(bad_q)); // R8
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int PRE_LOG2 = 2,
  parameter int CNT_W    = 6,
  localparam int NW  = CNT_W + PRE_LOG2,
  localparam int P   = 1 << PRE_LOG2,
  localparam int PCW = PRE_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_by_ratio,
  input  logic [CNT_W-1:0] cfg_swallow,
  input  logic [CNT_W-1:0] cfg_main,
  input  logic [NW-1:0] cfg_ratio,
  output logic          div_pulse,
  output logic          cfg_invalid
);
  logic [CNT_W-1:0] sel_a, sel_b, a_cnt, b_cnt;
  logic             sel_bad, swallow_nxt, end_evt, pre_tc, bad_q;
  logic [PCW-1:0]   pre_cnt;

  psd_cfg_front #(.PL(PRE_LOG2), .BW(CNT_W)) u_front (
    .by_ratio(cfg_by_ratio), .dir_a(cfg_swallow), .dir_b(cfg_main),
    .ratio_n(cfg_ratio), .sel_a(sel_a), .sel_b(sel_b), .sel_bad(sel_bad)
  );

  psd_swallow_ctrl #(.BW(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .pre_tc(pre_tc), .ld_a(sel_a), .ld_b(sel_b),
    .ld_bad(sel_bad), .a_cnt(a_cnt), .b_cnt(b_cnt),
    .swallow_nxt(swallow_nxt), .end_evt(end_evt), .bad_q(bad_q)
  );

  psd_prescaler #(.PL(PRE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .swallow_nxt(swallow_nxt),
    .pre_cnt(pre_cnt), .pre_tc(pre_tc)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= end_evt;
  end

  assign cfg_invalid = bad_q;

  AST_MOD_WIDE: assert property (@(posedge clk) disable iff (rst)
    pre_tc && !end_evt && (a_cnt > CNT_W'(1)) |=> pre_cnt == PCW'(P)); // R3
  AST_MOD_NARROW: assert property (@(posedge clk) disable iff (rst)
    pre_tc && !end_evt && (a_cnt <= CNT_W'(1)) |=> pre_cnt == PCW'(P - 1)); // R3
  AST_MAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    pre_tc && !end_evt |=> b_cnt == $past(b_cnt) - CNT_W'(1)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse); // R4
endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 2;
  localparam int BW = 6;
  localparam int NW = BW + PL;
  localparam int P  = 4;
  localparam int NCFG = 13;

  typedef struct { bit mode; int a; int b; int n; } cfg_t;
  typedef struct { int len; bit bad; } exp_t;

  logic clk = 1'b0, rst = 1'b1, cfg_by_ratio = 1'b0;
  logic [BW-1:0] cfg_swallow = '0, cfg_main = '0;
  logic [NW-1:0] cfg_ratio = '0;
  logic div_pulse, cfg_invalid;

  int n_checks = 0, n_fail = 0, cyc = 0;
  exp_t q[$];
  cfg_t plan[NCFG];

  pulse_swallow_div #(.PRE_LOG2(PL), .CNT_W(BW)) dut (
    .clk(clk), .rst(rst), .cfg_by_ratio(cfg_by_ratio), .cfg_swallow(cfg_swallow),
    .cfg_main(cfg_main), .cfg_ratio(cfg_ratio), .div_pulse(div_pulse),
    .cfg_invalid(cfg_invalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;

  function automatic exp_t predict(cfg_t c);
    exp_t e; int a, b, eb;
    if (c.mode) begin a = c.n % P; b = c.n / P; e.bad = (c.n < P*(P-1)); end
    else begin a = c.a; b = c.b; e.bad = (b == 0) || (a > b); end
    eb = (b == 0) ? 1 : b;
    e.len = (a <= eb) ? (eb*P + a) : (eb*(P+1));
    return e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic apply(cfg_t c);
    cfg_by_ratio = c.mode; cfg_swallow = BW'(c.a); cfg_main = BW'(c.b); cfg_ratio = NW'(c.n);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic driver();
    cfg_t decoy;
    for (int i = 1; i < NCFG + 2; i++) begin
      int k = (i < NCFG) ? i : NCFG - 1;
      wait_pulse();
      if (k == 9 || k == 10) begin
        // R8: short-lived invalid value before the real one, all inside one period
        decoy = '{mode: (k == 10), a: 7, b: 1, n: 11};
        apply(decoy);
        repeat (2) @(negedge clk);
      end
      apply(plan[k]);
      q.push_back(predict(plan[k]));
    end
  endtask

  task automatic monitor();
    exp_t held; int last = 0;
    for (int j = 0; j <= NCFG + 1; j++) begin
      wait_pulse();
      if (j > 0) begin
        check(cyc - last == held.len, "R2/R5/R6/R7/R8 period", cyc - last, held.len);
      end
      @(negedge clk); check(div_pulse == 1'b0, "R4 pulse width", int'(div_pulse), 0);
      last = cyc - 1;
      if (j <= NCFG) begin
        if (q.size() == 0) check(1'b0, "R8 queue underflow", 0, 1);
        else begin
          held = q.pop_front();
          check(cfg_invalid == held.bad, "R6/R7 invalid flag", int'(cfg_invalid), int'(held.bad));
        end
      end
    end
  endtask

  initial begin
    plan[0]  = '{0, 2, 3, 0};    // R2 14
    plan[1]  = '{0, 0, 5, 0};    // R2 20
    plan[2]  = '{0, 3, 3, 0};    // R2 A equals B: 15
    plan[3]  = '{0, 5, 2, 0};    // R6 B<A: 10, invalid
    plan[4]  = '{0, 0, 0, 0};    // R6 B=0: 4, invalid
    plan[5]  = '{0, 3, 0, 0};    // R6 B=0 A>0: 5, invalid
    plan[6]  = '{1, 9, 1, 12};   // R5 minimum continuous ratio, split inputs ignored
    plan[7]  = '{1, 0, 9, 11};   // R7 below minimum: 10, invalid
    plan[8]  = '{1, 0, 0, 255};  // R5 largest ratio
    plan[9]  = '{1, 0, 0, 50};   // R5 and R8 with decoy
    plan[10] = '{0, 1, 63, 0};   // R2 and R8 with decoy: 253
    plan[11] = '{0, 63, 1, 0};   // R6: 5, invalid
    plan[12] = '{0, 0, 1, 0};    // R2 smallest: 4
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1;
    apply(plan[0]);
    q.push_back(predict(plan[0]));
    repeat (5) begin
      @(negedge clk);
      check(div_pulse == 1'b0, "R1 pulse low in reset", int'(div_pulse), 0);
    end
    check(cfg_invalid == 1'b0, "R1 flag after reset", int'(cfg_invalid), 0);
    rst = 1'b0;
    fork
      driver();
      monitor();
    join
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule